// File: doc/BRIEF.md
# Battery Health Probe Sequencer

This block runs on the host side of a battery-backed byte-wide static memory with an asynchronous parallel bus. After a single start pulse at power-up, it runs four bus accesses on one address that the host chooses. First it reads the stored byte and keeps it. Then it writes the inverse of that byte. It reads the location again and compares the result with the inverse. Finally it writes the kept byte back.

The memory silently discards the first write after power-up when its backup cell is weak. A read-back that still returns the old value therefore means the battery is low. In both outcomes the sequencer restores the original byte. Only after that does it raise a one-cycle completion pulse, and it holds the verdict until the next start.

Every bus timing is given in nanoseconds together with the clock period. The sequencer turns each one into a cycle count, so the same code meets the memory's access, pulse, setup, hold and cycle limits at any clock rate.

Top module: `batt_check_seq`

## Requirements
- R1: While reset is low and after it is released, all three strobes are high (inactive), the host data driver is off, and done, battery_ok and busy are 0.
- R2: On an accepted start, the first access is a read of the address on test_addr. That address is captured at start and used for all four accesses. The value sampled is kept as the original byte.
- R3: The first write places the bitwise inverse of the original byte at the captured address.
- R4: The second read is compared with the inverse of the original. On a match, battery_ok is set to 1 at the end of the run. Otherwise it is set to 0.
- R5: The second write always puts the original byte back at the captured address, whether or not the check passed.
- R6: Whenever the write strobe is low, the output-enable strobe is high, chip enable is low and the host drives the data bus. The address does not change while chip enable stays low.
- R7: With the default 10 ns clock, the write strobe stays low for at least 5 cycles. Write data is valid for at least 3 sampled cycles before the strobe rises, and is still driven and unchanged in the cycle after the rise. Every access keeps chip enable low for at least 7 cycles.
- R8: Read data is taken no earlier than 70 ns after chip enable falls with the address stable, and no earlier than 35 ns after output enable falls. Data taken earlier would be wrong.
- R9: The host driver and the memory's output enable are never active together. Output enable falls only after the host driver has been off for at least one full cycle.
- R10: Each access occupies 8 clock cycles with the default timings, so busy is high for exactly 32 cycles after the start edge. done is high for exactly the one cycle after busy falls. battery_ok keeps its value until the next accepted start, which clears it to 0.
- R11: A start while busy is ignored. The run keeps its captured address and its length, and no other address is touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check run when idle |
| test_addr | input | ADDR_W | Address to probe, captured at start |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dout | output | DATA_W | Data driven toward the memory |
| mem_din | input | DATA_W | Data returned by the memory |
| mem_dq_oe | output | 1 | Host data driver enable |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| done | output | 1 | One-cycle pulse when a run completes |
| battery_ok | output | 1 | Verdict of the last run |
| busy | output | 1 | A run is in progress |

## Verification
The embedded properties check on every cycle the rules about how the strobes relate to each other:
- no bus contention, and a one-cycle release of the host driver before output enable falls;
- output enable held high and data driven while the write strobe is low;
- a stable address during chip enable;
- the single-cycle done pulse and the ignored start.

The remaining requirements need the bench's memory model:
- Reads that come too early get corrupted data.
- Writes are measured for pulse, setup and hold.
- A weak-cell mode drops the first write.

Only a full run shows that the verdict is correct, that the original byte comes back in both outcomes, and that a second start during a run leaves other addresses untouched.

// File: rtl/batt_check_seq.sv
module batt_check_seq #(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int CLK_NS       = 10,
  parameter int RD_ADDR_NS   = 70,
  parameter int RD_OE_NS     = 35,
  parameter int WR_PULSE_NS  = 50,
  parameter int WR_SETUP_NS  = 30,
  parameter int WR_HOLD_NS   = 5,
  parameter int CYCLE_NS     = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] test_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_dq_oe,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              done,
  output logic              battery_ok,
  output logic              busy
);

  localparam int RD_AC  = (RD_ADDR_NS  + CLK_NS - 1) / CLK_NS;
  localparam int RD_OC  = (RD_OE_NS    + CLK_NS - 1) / CLK_NS;
  localparam int WR_PC  = (WR_PULSE_NS + CLK_NS - 1) / CLK_NS;
  localparam int WR_SC  = (WR_SETUP_NS + CLK_NS - 1) / CLK_NS;
  localparam int WR_HC  = (WR_HOLD_NS  + CLK_NS - 1) / CLK_NS;
  localparam int CYC_C  = (CYCLE_NS    + CLK_NS - 1) / CLK_NS;

  // read: ce low from cnt 0, oe low from cnt 1, sample at the end of cnt RD_S
  localparam int RD_S   = (RD_AC - 1 > RD_OC) ? RD_AC - 1 : RD_OC;
  localparam int RD_L   = RD_S + 1;
  // write: data from cnt 0, strobe low cnt 1..WE_E, data held through DQ_E
  localparam int WE_E   = (WR_PC > WR_SC - 1) ? WR_PC : WR_SC - 1;
  localparam int DQ_E   = WE_E + WR_HC;
  localparam int WR_A   = (DQ_E > CYC_C - 1) ? DQ_E : CYC_C - 1;
  localparam int WR_L   = WR_A + 1;
  localparam int MAX_L  = (RD_L > WR_L) ? RD_L : WR_L;
  localparam int CNT_W  = $clog2(MAX_L + 1) + 1;

  localparam logic [CNT_W-1:0] C_RD_S = CNT_W'(RD_S);
  localparam logic [CNT_W-1:0] C_RD_L = CNT_W'(RD_L);
  localparam logic [CNT_W-1:0] C_WE_E = CNT_W'(WE_E);
  localparam logic [CNT_W-1:0] C_DQ_E = CNT_W'(DQ_E);
  localparam logic [CNT_W-1:0] C_WR_A = CNT_W'(WR_A);
  localparam logic [CNT_W-1:0] C_WR_L = CNT_W'(WR_L);
  localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} state_t;

  state_t            st;
  logic [1:0]        op;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] orig;
  logic              rb_ok;
  logic [ADDR_W-1:0] addr_q;

  wire in_rd     = (st == S_READ);
  wire in_wr     = (st == S_WRITE);
  wire rd_sample = in_rd && (cnt == C_RD_S);
  wire ph_end    = (in_rd && cnt == C_RD_L) || (in_wr && cnt == C_WR_L);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      op         <= '0;
      cnt        <= '0;
      orig       <= '0;
      rb_ok      <= 1'b0;
      addr_q     <= '0;
      done       <= 1'b0;
      battery_ok <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          st         <= S_READ;
          op         <= 2'd0;
          cnt        <= '0;
          addr_q     <= test_addr;
          battery_ok <= 1'b0;
        end
      end else begin
        cnt <= cnt + C_ONE;
        if (rd_sample) begin
          if (op == 2'd0) orig <= mem_din;
          else            rb_ok <= (mem_din == ~orig);
        end
        if (ph_end) begin
          cnt <= '0;
          if (op == 2'd3) begin
            st         <= S_IDLE;
            done       <= 1'b1;
            battery_ok <= rb_ok;
          end else begin
            op <= op + 2'd1;
            st <= op[0] ? S_READ : S_WRITE;
          end
        end
      end
    end
  end

  assign busy      = (st != S_IDLE);
  assign mem_addr  = addr_q;
  assign mem_dout  = op[1] ? orig : ~orig;
  assign mem_ce_n  = !((in_rd && cnt <= C_RD_S) || (in_wr && cnt <= C_WR_A));
  assign mem_oe_n  = !(in_rd && cnt >= C_ONE && cnt <= C_RD_S);
  assign mem_we_n  = !(in_wr && cnt >= C_ONE && cnt <= C_WE_E);
  assign mem_dq_oe = in_wr && (cnt <= C_DQ_E);

  p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  p_release_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !$past(mem_dq_oe));

  p_write_strobes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n));

  p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dout)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mem_addr));

endmodule

// File: tb/batt_check_seq_tb.sv
module batt_check_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [14:0] test_addr = '0;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dout;
  logic [7:0]  mem_din = '0;
  logic        mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
  logic        done, battery_ok, busy;

  int nchk = 0, nerr = 0, cyc = 0;

  batt_check_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .test_addr(test_addr),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_din(mem_din),
    .mem_dq_oe(mem_dq_oe), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .done(done), .battery_ok(battery_ok), .busy(busy)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model and reference model
  logic [7:0]  mem [int];
  logic [7:0]  wlog [$];
  bit          drop_next = 0;
  logic        prev_ce = 1, prev_oe = 1, prev_we = 1, prev_dq = 0;
  logic [7:0]  prev_dout = '0, wdata = '0;
  int          ce_cnt = 0, oe_cnt = 0, we_cnt = 0, dv_cnt = 0, dv_at_low = 0;
  bit          m_busy = 0, m_done = 0, m_ok = 0, m_exp_ok = 0;
  int          m_rem = 0;
  logic [14:0] m_addr = '0;

  function automatic logic [7:0] rd(input int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_ok = 0; m_rem = 0;
      prev_ce = 1; prev_oe = 1; prev_we = 1; prev_dq = 0;
      ce_cnt = 0; oe_cnt = 0; we_cnt = 0; dv_cnt = 0;
    end else begin
      m_done = 0;
      if (!m_busy && start) begin
        m_busy = 1; m_rem = 32; m_ok = 0; m_addr = test_addr;
      end else if (m_busy) begin
        m_rem--;
        if (m_rem == 0) begin m_busy = 0; m_done = 1; m_ok = m_exp_ok; end
      end
      check(busy == m_busy, "R10/R11 busy", busy, m_busy);
      check(done == m_done, "R10 done", done, m_done);
      check(battery_ok == m_ok, "R10/R4 battery_ok", battery_ok, m_ok);

      if (!mem_ce_n) check(mem_addr == m_addr, "R11/R2 address", mem_addr, m_addr);
      if (!mem_oe_n) check(!mem_dq_oe && !prev_dq, "R9 turnaround", {prev_dq, mem_dq_oe}, 0);

      if (mem_ce_n && !prev_ce) check(ce_cnt >= 7, "R7 cycle length", ce_cnt, 7);
      ce_cnt = mem_ce_n ? 0 : ce_cnt + 1;
      oe_cnt = mem_oe_n ? 0 : oe_cnt + 1;
      if (mem_dq_oe) dv_cnt = (prev_dq && mem_dout == prev_dout) ? dv_cnt + 1 : 1;
      else           dv_cnt = 0;

      if (!mem_we_n) begin
        if (prev_we) begin
          we_cnt = 1; wdata = mem_dout;
        end else begin
          we_cnt++;
          check(mem_dout == wdata, "R7 data stable", mem_dout, wdata);
        end
        dv_at_low = dv_cnt;
        check(mem_oe_n && mem_dq_oe && !mem_ce_n, "R6 write strobes",
              {mem_oe_n, mem_dq_oe, mem_ce_n}, 3'b110);
      end else if (!prev_we) begin
        check(we_cnt >= 5, "R7 pulse width", we_cnt, 5);
        check(dv_at_low >= 3, "R7 setup", dv_at_low, 3);
        check(mem_dq_oe && mem_dout == wdata, "R7 hold", mem_dout, wdata);
        wlog.push_back(wdata);
        if (drop_next) drop_next = 0;
        else mem[int'(mem_addr)] = wdata;
      end

      // R8: valid data only once both access windows have elapsed
      if (!mem_ce_n && !mem_oe_n && ce_cnt >= 7 && oe_cnt >= 4)
        mem_din = rd(int'(mem_addr));
      else
        mem_din = rd(int'(mem_addr)) ^ 8'h3C;

      prev_ce = mem_ce_n; prev_oe = mem_oe_n; prev_we = mem_we_n;
      prev_dq = mem_dq_oe; prev_dout = mem_dout;
    end
  end

  task automatic pulse_start(input logic [14:0] a);
    @(negedge clk); #2;
    test_addr = a; start = 1'b1;
    @(negedge clk); #2;
    start = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
    #1;
  endtask

  task automatic run(input logic [14:0] a, input logic [7:0] v, input bit bad);
    mem[int'(a)] = v;
    drop_next = bad;
    m_exp_ok = !bad;
    wlog.delete();
    pulse_start(a);
    wait_done();
    check(battery_ok == !bad, "R4 verdict", battery_ok, !bad);
    check(wlog.size() == 2, "R3/R5 write count", wlog.size(), 2);
    if (wlog.size() == 2) begin
      check(wlog[0] == ~v, "R3 inverse written", wlog[0], ~v);
      check(wlog[1] == v, "R5 original rewritten", wlog[1], v);
    end
    check(rd(int'(a)) == v, "R5 restored R2 read", rd(int'(a)), v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe} == 4'b1110, "R1 strobes in reset",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    check({done, battery_ok, busy} == 3'b000, "R1 outputs in reset",
          {done, battery_ok, busy}, 0);
    @(negedge clk); #2 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe} == 4'b1110, "R1 strobes idle",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);

    run(15'h1234, 8'h5A, 0);
    run(15'h7FFF, 8'h00, 0);
    run(15'h0000, 8'hFF, 1);
    run(15'h0000, 8'hC3, 0);

    // R10: verdict holds while idle
    repeat (10) @(negedge clk);
    #1;
    check(battery_ok == 1'b1 && !busy, "R10 verdict held", battery_ok, 1);

    // R11: second start during a run is ignored
    mem[int'(15'h0200)] = 8'h11;
    mem[int'(15'h0100)] = 8'hA7;
    m_exp_ok = 1;
    wlog.delete();
    pulse_start(15'h0100);
    repeat (8) @(negedge clk);
    pulse_start(15'h0200);
    wait_done();
    check(rd(int'(15'h0200)) == 8'h11, "R11 other address untouched", rd(int'(15'h0200)), 8'h11);
    check(rd(int'(15'h0100)) == 8'hA7, "R11 probed address restored", rd(int'(15'h0100)), 8'hA7);
    check(wlog.size() == 2, "R11 only one run", wlog.size(), 2);

    // R10: bad verdict then new start clears it
    run(15'h0042, 8'h81, 1);
    check(battery_ok == 1'b0, "R4 low battery flagged", battery_ok, 0);
    run(15'h0042, 8'h81, 0);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule